// File: doc/BRIEF.md
# Transparent Serial Bit Output with Sampling Strobe

This block presents decoded receive bits on a data line and adds an active-high strobe, so that an external device can sample each bit as it arrives instead of reading the receive FIFO. The data line carries the same bits that go into the FIFO. Each bit the decoder flags with a one-cycle valid pulse is accepted, placed on the data line, and followed by a single strobe pulse.

Strobe timing is measured in sixteenths of a bit. A run-time input gives the length of one sixteenth in clock cycles. The strobe rises one sixteenth after the data changes and falls one sixteenth later. Output is gated in three cases: transparent mode is disabled, frame synchronisation has not been reached, or the FIFO is locked. While gated, the data line idles low and any pending strobe is cancelled. As a result, wake-up, run-in and sync-word bits, which come before frame sync, never appear on the output.

Top module: `tso_top`

## Requirements
- R1: A bit accepted on a `bit_valid` pulse (with `xmode_en`=1, `frame_sync`=1, `fifo_lock`=0) appears on `data_out` on the clock after the pulse. It holds until the next accepted bit or until the output is gated.
- R2: While `frame_sync` is 0, `data_out` is low one clock later, `bit_valid` pulses are ignored, and no strobe is produced.
- R3: While `fifo_lock` is 1, `data_out` is low one clock later, `bit_valid` pulses are ignored, and any pending or active strobe is cancelled.
- R4: While `xmode_en` is 0, `data_out` and `strobe_out` are low one clock later, and `bit_valid` pulses are ignored.
- R5: `strobe_out` rises exactly S clock cycles after `data_out` takes an accepted bit, where S is the value on `sixteenth_len`.
- R6: `strobe_out` stays high for exactly S clock cycles, then stays low until a new bit is accepted.
- R7: A bit accepted while a strobe is pending or high restarts the sequence. `strobe_out` is low on the next clock, and it rises again S cycles after the new bit.
- R8: A `sixteenth_len` of 0 behaves as 1.
- R9: After reset, `data_out` and `strobe_out` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xmode_en | input | 1 | Transparent output enable |
| frame_sync | input | 1 | High once the frame is synchronised |
| fifo_lock | input | 1 | High while the receive FIFO is locked |
| bit_in | input | 1 | Decoded data bit |
| bit_valid | input | 1 | One-cycle pulse marking `bit_in` valid |
| sixteenth_len | input | LEN_W (8) | Clock cycles in one sixteenth of a bit |
| data_out | output | 1 | Transparent data line |
| strobe_out | output | 1 | Active-high sampling strobe |

## Verification
The bench measures where the strobe edges fall, cycle by cycle, for several sixteenth lengths, including 1 and the value 0. An off-by-one timer would shift the edges or stretch the pulse, and missing zero handling would stall or wrap the timer. It sends bits before sync, under lock and with the mode disabled. A design with a leaky gate would show those bits or emit a strobe. It also sends a new bit in the middle of a pending strobe and in the middle of an active strobe. A design without restart would keep the old timing and show a strobe edge at the wrong cycle.

// File: rtl/tso_pkg.sv
package tso_pkg;
   // Phase of the strobe sequencer
   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_t;
endpackage

// File: rtl/tso_sixteenth_timer.sv
module tso_sixteenth_timer #(
   parameter int  LEN_W       = 8,
   parameter bit  ZERO_AS_ONE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [LEN_W-1:0] len,
   output logic             tick
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [LEN_W-1:0] lim;
   logic [LEN_W-1:0] cnt_q;

   generate
      if (ZERO_AS_ONE) begin : g_clamp
         assign lim = (len == '0) ? '0 : len - ONE;
      end else begin : g_wrap
         assign lim = len - ONE;
      end
   endgenerate

   assign tick = run && !restart && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || !run) begin
         cnt_q <= '0;
      end else if (cnt_q == lim) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end

   // R8: the count never passes the limit once running
   a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !restart && $stable(len)) |=> (cnt_q <= lim || $changed(len)));
endmodule

// File: rtl/tso_bit_gate.sv
module tso_bit_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic xmode_en,
   input  logic frame_sync,
   input  logic fifo_lock,
   input  logic bit_in,
   input  logic bit_valid,
   output logic accept,
   output logic gate_off,
   output logic data_q
);
   assign gate_off = !xmode_en || !frame_sync || fifo_lock;
   assign accept   = bit_valid && !gate_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= 1'b0;
      end else if (gate_off) begin
         data_q <= 1'b0;
      end else if (accept) begin
         data_q <= bit_in;
      end
   end

   a_r2_no_data_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_sync |=> !data_q);
   a_r3_no_data_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_lock |=> !data_q);
   a_r1_bit_taken: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (data_q == $past(bit_in)));
endmodule

// File: rtl/tso_strobe_seq.sv
module tso_strobe_seq
   import tso_pkg::*;
#(
   parameter int DLY_SIXTEENTHS = 1,
   parameter int LEN_SIXTEENTHS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic cancel,
   input  logic tick,
   output logic running,
   output logic strobe_q
);
   localparam int TOTAL = DLY_SIXTEENTHS + LEN_SIXTEENTHS;
   localparam int PH_W  = $clog2(TOTAL + 1);
   localparam logic [PH_W-1:0] PH_ONE = PH_W'(1);
   localparam logic [PH_W-1:0] PH_DLY = PH_W'(DLY_SIXTEENTHS);
   localparam logic [PH_W-1:0] PH_END = PH_W'(TOTAL);

   seq_state_t      st_q;
   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] ph_nx;

   generate
      if (DLY_SIXTEENTHS < 1) begin : g_bad_dly
         $error("strobe delay must be at least one sixteenth");
      end
      if (LEN_SIXTEENTHS < 1) begin : g_bad_len
         $error("strobe length must be at least one sixteenth");
      end
   endgenerate

   assign ph_nx   = ph_q + PH_ONE;
   assign running = (st_q == SEQ_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SEQ_IDLE;
         ph_q     <= '0;
         strobe_q <= 1'b0;
      end else if (cancel) begin
         st_q     <= SEQ_IDLE;
         ph_q     <= '0;
         strobe_q <= 1'b0;
      end else if (accept) begin
         st_q     <= SEQ_RUN;
         ph_q     <= '0;
         strobe_q <= 1'b0;
      end else if (running && tick) begin
         ph_q     <= ph_nx;
         strobe_q <= (ph_nx >= PH_DLY) && (ph_nx < PH_END);
         if (ph_nx == PH_END) begin
            st_q <= SEQ_IDLE;
         end
      end
   end

   a_r7_restart_drops_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !strobe_q);
   a_r4_cancel_drops_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> (!strobe_q && !running));
   a_r6_strobe_only_while_running: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_q |-> running);
endmodule

// File: rtl/tso_top.sv
module tso_top #(
   parameter int LEN_W          = 8,
   parameter int DLY_SIXTEENTHS = 1,
   parameter int LEN_SIXTEENTHS = 1,
   parameter bit ZERO_AS_ONE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xmode_en,
   input  logic             frame_sync,
   input  logic             fifo_lock,
   input  logic             bit_in,
   input  logic             bit_valid,
   input  logic [LEN_W-1:0] sixteenth_len,
   output logic             data_out,
   output logic             strobe_out
);
   logic accept;
   logic gate_off;
   logic running;
   logic tick;

   generate
      if (LEN_W < 1) begin : g_bad_w
         $error("LEN_W must be at least 1");
      end
   endgenerate

   tso_bit_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .xmode_en   (xmode_en),
      .frame_sync (frame_sync),
      .fifo_lock  (fifo_lock),
      .bit_in     (bit_in),
      .bit_valid  (bit_valid),
      .accept     (accept),
      .gate_off   (gate_off),
      .data_q     (data_out)
   );

   tso_sixteenth_timer #(
      .LEN_W       (LEN_W),
      .ZERO_AS_ONE (ZERO_AS_ONE)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept || gate_off),
      .run     (running),
      .len     (sixteenth_len),
      .tick    (tick)
   );

   tso_strobe_seq #(
      .DLY_SIXTEENTHS (DLY_SIXTEENTHS),
      .LEN_SIXTEENTHS (LEN_SIXTEENTHS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .cancel   (gate_off),
      .tick     (tick),
      .running  (running),
      .strobe_q (strobe_out)
   );

   a_r5_data_steady_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_out |-> $stable(data_out));
   a_r4_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !xmode_en |=> (!data_out && !strobe_out));
   a_r9_reset_idle: assert property (@(posedge clk)
      !rst_n |-> (!data_out && !strobe_out));
endmodule

// File: tb/tso_top_tb_top.sv
module tso_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xmode_en = 1'b0;
   logic       frame_sync = 1'b0;
   logic       fifo_lock = 1'b0;
   logic       bit_in = 1'b0;
   logic       bit_valid = 1'b0;
   logic [7:0] sixteenth_len = 8'd1;
   logic       data_out;
   logic       strobe_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tso_top dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .xmode_en      (xmode_en),
      .frame_sync    (frame_sync),
      .fifo_lock     (fifo_lock),
      .bit_in        (bit_in),
      .bit_valid     (bit_valid),
      .sixteenth_len (sixteenth_len),
      .data_out      (data_out),
      .strobe_out    (strobe_out)
   );

   // vector: {bit, sixteenth length}
   localparam logic [8:0] VEC [6] = '{
      {1'b1, 8'd1}, {1'b0, 8'd2}, {1'b1, 8'd3},
      {1'b1, 8'd5}, {1'b0, 8'd4}, {1'b1, 8'd7}
   };

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic send_bit(input logic b);
      bit_in    = b;
      bit_valid = 1'b1;
      @(negedge clk);
      bit_valid = 1'b0;
   endtask

   // after send_bit: k=0 is one edge after acceptance
   task automatic walk_strobe(input string req, input logic b, input int s);
      for (int k = 0; k <= 2 * s + 1; k++) begin
         chk(req, strobe_out, (k >= s) && (k < 2 * s));
         chk("R1 hold", data_out, b);
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk("R9 data", data_out, 1'b0);
      chk("R9 strobe", strobe_out, 1'b0);
      rst_n = 1'b1;
      xmode_en = 1'b1;
      @(negedge clk);

      // R2: bits before frame sync are dropped
      send_bit(1'b1);
      chk("R2 data", data_out, 1'b0);
      repeat (3) begin
         chk("R2 strobe", strobe_out, 1'b0);
         @(negedge clk);
      end

      frame_sync = 1'b1;
      @(negedge clk);

      // table walk: R1, R5, R6
      foreach (VEC[i]) begin
         sixteenth_len = VEC[i][7:0];
         send_bit(VEC[i][8]);
         chk("R1 data", data_out, VEC[i][8]);
         walk_strobe("R5/R6 strobe", VEC[i][8], int'(VEC[i][7:0]));
      end

      // R8: zero length acts as one
      sixteenth_len = 8'd0;
      send_bit(1'b0);
      walk_strobe("R8 zero len", 1'b0, 1);

      // R7: restart while strobe pending
      sixteenth_len = 8'd4;
      send_bit(1'b1);
      repeat (2) @(negedge clk);
      send_bit(1'b0);
      walk_strobe("R7 restart pending", 1'b0, 4);

      // R7: restart while strobe high
      send_bit(1'b1);
      repeat (5) @(negedge clk);
      chk("R7 strobe high", strobe_out, 1'b1);
      send_bit(1'b0);
      chk("R7 drop", strobe_out, 1'b0);
      walk_strobe("R7 restart active", 1'b0, 4);

      // R3: lock cancels active strobe and blocks bits
      send_bit(1'b1);
      repeat (4) @(negedge clk);
      fifo_lock = 1'b1;
      @(negedge clk);
      chk("R3 data", data_out, 1'b0);
      chk("R3 strobe", strobe_out, 1'b0);
      send_bit(1'b1);
      for (int k = 0; k < 10; k++) begin
         chk("R3 quiet", strobe_out | data_out, 1'b0);
         @(negedge clk);
      end
      fifo_lock = 1'b0;
      @(negedge clk);

      // R4: disable blocks bits and idles low
      send_bit(1'b1);
      xmode_en = 1'b0;
      @(negedge clk);
      chk("R4 data", data_out, 1'b0);
      send_bit(1'b1);
      for (int k = 0; k < 10; k++) begin
         chk("R4 quiet", strobe_out | data_out, 1'b0);
         @(negedge clk);
      end

      // R2: losing sync idles the line
      xmode_en = 1'b1;
      sixteenth_len = 8'd2;
      send_bit(1'b1);
      frame_sync = 1'b0;
      @(negedge clk);
      chk("R2 sync lost", data_out, 1'b0);
      chk("R2 sync lost strobe", strobe_out, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule